// File: doc/BRIEF.md
# Broadcast Descriptor Timeout Status Tracker

This block follows one broadcast message descriptor from the moment it is launched until it has an outcome. An activate pulse starts it. From then on it waits for the destination to acknowledge. A programmable watchdog runs while it waits, and it counts an external microsecond tick. The block reports progress and outcome as a sparse 3-bit status code, and it raises a one-cycle done flag when the descriptor completes cleanly.

A 4-bit timeout field sets the watchdog period. The top bit chooses a base of 10 or 80 microseconds, and the lower three bits multiply that base. Error outcomes stay in the status register until the next activation: destination timeout, strong negative acknowledge, source-side timeout and destination put failure. Software or a sequencer can therefore read the cause and relaunch.

Top module: `bcast_desc_tracker`

## Requirements
- R1: After reset, status is 0 (idle) and done is 0.
- R2: An activate pulse while status is idle (0) or any error code (4, 5, 6, 7) makes status 2 (busy) on the next clock and restarts the watchdog from zero.
- R3: An activate pulse while status is busy has no effect: the watchdog keeps its count and its period.
- R4: The watchdog expires on the N-th tick seen while busy, where N = multiplier × base. The base is 80 when field bit 3 is 1 and 10 when it is 0. The multiplier is field bits 2:0. Field 15 gives 560. On expiry status becomes 4 on the next clock.
- R5: A multiplier of 0 disables the watchdog, so status stays busy whatever the number of ticks.
- R6: The timeout field is sampled only on the activating cycle. Later changes do not alter the running period.
- R7: A destination acknowledge while busy returns status to 0 and sets done to 1 for exactly one cycle, on the same clock.
- R8: While busy, a strong negative acknowledge gives status 5, a source-side timeout gives 6, and a put failure gives 7.
- R9: When events coincide while busy, the winner in descending priority is put failure, source timeout, strong negative acknowledge, watchdog expiry, then acknowledge.
- R10: Event pulses and acknowledges while status is not busy change neither status nor done.
- R11: Status codes 1 and 3 never appear, and done is only ever high together with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| activate | input | 1 | Launch pulse for the descriptor |
| tmo_field | input | 4 | Timeout code: bit 3 base select, bits 2:0 multiplier |
| dest_ack | input | 1 | Destination acknowledge pulse |
| strong_nack | input | 1 | Strong negative acknowledge pulse |
| src_timeout | input | 1 | Source-side timeout pulse |
| put_fail | input | 1 | Destination put failure pulse |
| status | output | 3 | Descriptor status code (error, busy, aux bits) |
| done | output | 1 | One-cycle clean completion flag |

## Verification
The hardest collision is the watchdog expiring on the same cycle that the acknowledge arrives. The bench provokes it by counting ticks exactly: it launches with a ten-tick period and raises the acknowledge together with the tenth tick. The expected result is status 4 with done low. The same method pits expiry against a strong negative acknowledge, which must win with code 5. A behavioural model judges every cycle, including a long random phase in which ticks and events overlap freely.

// File: rtl/bdt_pkg.sv
package bdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_BUSY = 3'b010,
    ST_DTO  = 3'b100,
    ST_NACK = 3'b101,
    ST_STO  = 3'b110,
    ST_PUT  = 3'b111
  } bdt_status_e;
endpackage

// File: rtl/bdt_period_decode.sv
module bdt_period_decode #(
  parameter int FIELD_W = 4,
  parameter int BASE_LO = 10,
  parameter int BASE_HI = 80,
  parameter int CNT_W   = 10
) (
  input  logic [FIELD_W-1:0] field,
  output logic [CNT_W-1:0]   limit
);
  localparam int MULT_W = FIELD_W - 1;
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(BASE_LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(BASE_HI);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] mult;

  always_comb begin
    base  = field[FIELD_W-1] ? HI_C : LO_C;
    mult  = CNT_W'(field[MULT_W-1:0]);
    limit = CNT_W'(mult * base);
  end
endmodule

// File: rtl/bdt_timer.sv
module bdt_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_in,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= ZERO;
      cnt_q   <= ZERO;
    end else if (start) begin
      limit_q <= limit_in;
      cnt_q   <= ZERO;
    end else if (run && tick && !expire) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  always_comb begin
    expire = run && tick && (limit_q != ZERO) && (cnt_q == limit_q - ONE);
  end
endmodule

// File: rtl/bdt_status_fsm.sv
module bdt_status_fsm
  import bdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        act,
  input  logic        ack,
  input  logic        nack,
  input  logic        sto,
  input  logic        put,
  input  logic        expire,
  output bdt_status_e status,
  output logic        done,
  output logic        start,
  output logic        busy
);
  bdt_status_e st_q, st_d;
  logic        done_d;

  always_comb begin
    busy   = (st_q == ST_BUSY);
    start  = act && !busy;
    st_d   = st_q;
    done_d = 1'b0;
    if (start) begin
      st_d = ST_BUSY;
    end else if (busy) begin
      if (put)         st_d = ST_PUT;
      else if (sto)    st_d = ST_STO;
      else if (nack)   st_d = ST_NACK;
      else if (expire) st_d = ST_DTO;
      else if (ack) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/bcast_desc_tracker.sv
module bcast_desc_tracker
  import bdt_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int BASE_LO = 10,
  parameter int BASE_HI = 80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               us_tick,
  input  logic               activate,
  input  logic [FIELD_W-1:0] tmo_field,
  input  logic               dest_ack,
  input  logic               strong_nack,
  input  logic               src_timeout,
  input  logic               put_fail,
  output logic [2:0]         status,
  output logic               done
);
  localparam int MULT_W   = FIELD_W - 1;
  localparam int MULT_MAX = (1 << MULT_W) - 1;
  localparam int BASE_MAX = (BASE_HI > BASE_LO) ? BASE_HI : BASE_LO;
  localparam int LONGEST  = MULT_MAX * BASE_MAX;
  localparam int CNT_W    = $clog2(LONGEST + 1);

  logic [CNT_W-1:0] period;
  logic             tmr_expire;
  logic             tmr_start;
  logic             is_busy;
  bdt_status_e      st;

  bdt_period_decode #(
    .FIELD_W(FIELD_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .CNT_W(CNT_W)
  ) u_decode (
    .field(tmo_field),
    .limit(period)
  );

  bdt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .run(is_busy),
    .tick(us_tick), .limit_in(period), .expire(tmr_expire)
  );

  bdt_status_fsm u_fsm (
    .clk(clk), .rst(rst), .act(activate), .ack(dest_ack),
    .nack(strong_nack), .sto(src_timeout), .put(put_fail),
    .expire(tmr_expire), .status(st), .done(done),
    .start(tmr_start), .busy(is_busy)
  );

  assign status = st;
endmodule

// File: rtl/bdt_checker.sv
module bdt_checker (
  input logic       clk,
  input logic       rst,
  input logic       act,
  input logic       ack,
  input logic       nack,
  input logic       sto,
  input logic       put,
  input logic       expire,
  input logic [2:0] status,
  input logic       done
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_BUSY = 3'd2;

  a_r11_legal_code: assert property (@(posedge clk) disable iff (rst)
    (status != 3'd1) && (status != 3'd3));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (status == C_IDLE));

  a_r2_activate: assert property (@(posedge clk) disable iff (rst)
    (act && status != C_BUSY) |=> (status == C_BUSY));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (status == C_IDLE && !act) |=> (status == C_IDLE && !done));

  a_r8_put_code: assert property (@(posedge clk) disable iff (rst)
    (status == C_BUSY && put) |=> (status == 3'd7));

  a_r9_expire_over_ack: assert property (@(posedge clk) disable iff (rst)
    (status == C_BUSY && expire && !put && !sto && !nack) |=> (status == 3'd4 && !done));

  a_r7_ack_done: assert property (@(posedge clk) disable iff (rst)
    (status == C_BUSY && ack && !expire && !put && !sto && !nack)
      |=> (status == C_IDLE && done));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (status == C_BUSY && !ack && !nack && !sto && !put && !expire)
      |=> (status == C_BUSY));
endmodule

bind bcast_desc_tracker bdt_checker u_chk (
  .clk(clk), .rst(rst), .act(activate), .ack(dest_ack),
  .nack(strong_nack), .sto(src_timeout), .put(put_fail),
  .expire(tmr_expire), .status(status), .done(done)
);

// File: tb/bcast_desc_tracker_bench.sv
`timescale 1ns/1ps
module bcast_desc_tracker_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       us_tick = 1'b0, activate = 1'b0, dest_ack = 1'b0;
  logic       strong_nack = 1'b0, src_timeout = 1'b0, put_fail = 1'b0;
  logic [3:0] tmo_field = 4'd0;
  logic [2:0] status;
  logic       done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  int ref_st = 0;
  int ref_done = 0;
  int ref_cnt = 0;
  int ref_lim = 0;

  bcast_desc_tracker u_bcast_desc_tracker (
    .clk(clk), .rst(rst), .us_tick(us_tick), .activate(activate),
    .tmo_field(tmo_field), .dest_ack(dest_ack), .strong_nack(strong_nack),
    .src_timeout(src_timeout), .put_fail(put_fail),
    .status(status), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      ref_st <= 0; ref_done <= 0; ref_cnt <= 0; ref_lim <= 0;
    end else begin
      ref_done <= 0;
      if (ref_st != 2) begin
        if (activate) begin
          ref_st  <= 2;
          ref_cnt <= 0;
          ref_lim <= (tmo_field[3] ? 80 : 10) * int'(tmo_field[2:0]);
        end
      end else begin
        if (put_fail) ref_st <= 7;
        else if (src_timeout) ref_st <= 6;
        else if (strong_nack) ref_st <= 5;
        else if (us_tick && ref_lim != 0 && ref_cnt + 1 == ref_lim) ref_st <= 4;
        else begin
          if (dest_ack) begin ref_st <= 0; ref_done <= 1; end
          else if (us_tick) ref_cnt <= ref_cnt + 1;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    checks++;
    if (int'(status) != ref_st || int'(done) != ref_done) begin
      errors++;
      $display("FAIL %s model: status %0d done %0d expected %0d %0d",
               cur_req, status, done, ref_st, ref_done);
    end
    if (status == 3'd1 || status == 3'd3) begin
      errors++;
      $display("FAIL R11 illegal status %0d expected none of 1,3", status);
    end
  end

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input logic a, input logic t, input logic k,
                     input logic n, input logic s, input logic p);
    @(negedge clk);
    activate = a; us_tick = t; dest_ack = k;
    strong_nack = n; src_timeout = s; put_fail = p;
  endtask

  task automatic idle1();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0);
  endtask

  task automatic launch(input logic [3:0] f);
    @(negedge clk);
    tmo_field = f;
    activate = 1'b1; us_tick = 0; dest_ack = 0;
    strong_nack = 0; src_timeout = 0; put_fail = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 status", int'(status), 0);
    chk("R1 done", int'(done), 0);
    @(negedge clk); rst = 1'b0;

    // R4: field 2 -> 20 ticks
    cur_req = "R4";
    launch(4'd2); idle1();
    chk("R2 busy after launch", int'(status), 2);
    ticks(19); idle1();
    chk("R4 busy before 20th tick", int'(status), 2);
    ticks(1); idle1();
    chk("R4 timeout code after 20 ticks", int'(status), 4);

    // R2 relaunch from error, R7 ack
    cur_req = "R7";
    launch(4'd2); idle1();
    chk("R2 busy from error", int'(status), 2);
    cyc(0, 0, 1, 0, 0, 0); idle1();
    chk("R7 status idle", int'(status), 0);
    chk("R7 done high", int'(done), 1);
    idle1();
    chk("R7 done one cycle", int'(done), 0);

    // R4: longest period 560, ticks every other cycle
    cur_req = "R4";
    launch(4'd15); idle1();
    for (int i = 0; i < 559; i++) begin cyc(0, 1, 0, 0, 0, 0); idle1(); end
    chk("R4 busy at 559 of 560", int'(status), 2);
    ticks(1); idle1();
    chk("R4 timeout at 560", int'(status), 4);

    // R5: multiplier zero
    cur_req = "R5";
    launch(4'd8); idle1();
    ticks(700); idle1();
    chk("R5 disabled timeout", int'(status), 2);
    cyc(0, 0, 1, 0, 0, 0); idle1();

    // R6: field changes after launch ignored
    cur_req = "R6";
    launch(4'd1); idle1();
    tmo_field = 4'd15;
    ticks(9); idle1();
    chk("R6 busy before 10", int'(status), 2);
    ticks(1); idle1();
    chk("R6 original period kept", int'(status), 4);

    // R3: activate while busy ignored
    cur_req = "R3";
    launch(4'd2); idle1();
    ticks(10);
    cyc(1, 0, 0, 0, 0, 0);
    ticks(9); idle1();
    chk("R3 busy before 20", int'(status), 2);
    ticks(1); idle1();
    chk("R3 count not restarted", int'(status), 4);

    // R8 error codes
    cur_req = "R8";
    launch(4'd0); idle1(); cyc(0, 0, 0, 1, 0, 0); idle1();
    chk("R8 strong nack code", int'(status), 5);
    launch(4'd0); idle1(); cyc(0, 0, 0, 0, 1, 0); idle1();
    chk("R8 source timeout code", int'(status), 6);
    launch(4'd0); idle1(); cyc(0, 0, 0, 0, 0, 1); idle1();
    chk("R8 put failure code", int'(status), 7);

    // R9 priority
    cur_req = "R9";
    launch(4'd1); idle1(); ticks(9); cyc(0, 1, 1, 1, 1, 1); idle1();
    chk("R9 put wins all", int'(status), 7);
    launch(4'd1); idle1(); ticks(9); cyc(0, 1, 1, 1, 1, 0); idle1();
    chk("R9 source timeout over nack", int'(status), 6);
    launch(4'd1); idle1(); ticks(9); cyc(0, 1, 1, 1, 0, 0); idle1();
    chk("R9 nack over expiry", int'(status), 5);
    launch(4'd1); idle1(); ticks(9); cyc(0, 1, 1, 0, 0, 0); idle1();
    chk("R9 expiry over ack", int'(status), 4);
    chk("R9 no done on expiry", int'(done), 0);

    // R10 events while not busy
    cur_req = "R10";
    launch(4'd0); idle1(); cyc(0, 0, 1, 0, 0, 0); idle1();
    cyc(0, 1, 1, 1, 1, 1); idle1();
    chk("R10 idle unchanged", int'(status), 0);
    chk("R10 no done", int'(done), 0);
    launch(4'd0); idle1(); cyc(0, 0, 0, 1, 0, 0); idle1();
    cyc(0, 1, 1, 0, 1, 1); idle1();
    chk("R10 error code held", int'(status), 5);

    // random phase against the model
    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tmo_field   = 4'($urandom_range(0, 15));
      activate    = ($urandom_range(0, 19) == 0);
      us_tick     = ($urandom_range(0, 1) == 0);
      dest_ack    = ($urandom_range(0, 29) == 0);
      strong_nack = ($urandom_range(0, 79) == 0);
      src_timeout = ($urandom_range(0, 79) == 0);
      put_fail    = ($urandom_range(0, 79) == 0);
    end
    idle1(); idle1();
    finish_run();
  end
endmodule